// File: doc/BRIEF.md
# Dispatch Group Former

This block sits between decode and dispatch. Each cycle it looks at a window of up to eight decoded instructions, held in program order. It cuts the longest legal prefix of that window into one dispatch group. Dispatch and completion then handle the group as a single unit.

The cut follows the slot and termination rules of the back end. These rules depend on the instruction class, the micro-op crack count, the number of branches and non-branches already placed, and per-instruction ordering flags. The block never reorders instructions. Anything it does not take stays in the upstream window and opens the next group.

A mode input picks the group width: 8 slots for single-thread operation or 4 slots for multithread operation. The formed group is held in an output register that uses a valid/ready handshake. The input side reports how many window entries it consumed in the cycle of acceptance.

Top module: `grp_former`

## Requirements
- R1: The group holds at most 8 instructions when `mt_i`=0 and at most 4 when `mt_i`=1. It never holds more than `win_cnt_i`. `take_o` gives the number of window entries placed, taken from entry 0 upward. `take_o` is 0 in any cycle without acceptance.
- R2: Class codes in control bits [1:0] are 0 plain, 1 branch, 2 predicated branch and 3 floating point. Every class except 1 counts as a non-branch. A group holds at most 6 non-branches, and an instruction that would be the seventh starts the next group.
- R3: A group holds at most 2 branches. Placing the second branch closes the group after it.
- R4: A predicated branch may sit only in slot 5 (8-wide) or slot 3 (4-wide), or in slot 0. Anywhere else the group closes before it.
- R5: An instruction with crack count 2 (control bits [3:2]) may sit only in slots 0–3 (8-wide) or 0–1 (4-wide). Otherwise the group closes before it. A crack field of 0 is treated as 1.
- R6: An instruction with crack count 3 closes the group after it.
- R7: A floating-point instruction is never placed after a branch in the same group. The group closes before it.
- R8: An instruction with the start flag (bit 4) closes the group before it unless it is in slot 0. An instruction with the end flag (bit 5) closes the group after it. With both flags set, the instruction forms a group alone.
- R9: Slot 0 accepts any instruction, so every acceptance with `win_cnt_i`>0 consumes at least one entry. `in_valid_i` with `win_cnt_i`=0 accepts nothing and forms no group.
- R10: `in_ready_o` is high when the output register is empty or `grp_ready_i` is high. While `grp_valid_o` is high and `grp_ready_i` is low, the group, its mask and `grp_valid_o` hold their values and nothing is consumed.
- R11: In the registered group, `grp_mask_o` has its low `take` bits set. Slot i carries window entry i's control and tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mt_i | input | 1 | 1 selects the 4-wide multithread group |
| in_valid_i | input | 1 | Window holds instructions |
| in_ready_o | output | 1 | Window can be consumed this cycle |
| win_cnt_i | input | 4 | Number of valid window entries (0..8) |
| win_ctrl_i | input | 48 | Entry i control at bits [6i+5:6i] |
| win_tag_i | input | 64 | Entry i tag at bits [8i+7:8i] |
| take_o | output | 4 | Entries consumed this cycle |
| grp_valid_o | output | 1 | Output group valid |
| grp_ready_i | input | 1 | Dispatch accepts the group |
| grp_mask_o | output | 8 | Occupied slots of the group |
| grp_ctrl_o | output | 48 | Slot control fields |
| grp_tag_o | output | 64 | Slot tags |

## Verification
Two kinds of overlap are exercised. The first is a termination rule and a placement rule landing on the same instruction or on neighbouring ones. Examples are a seventh non-branch that is also a misplaced predicated branch, and a second branch followed by a floating-point op. These come from directed windows and from a long pseudo-random sweep in both widths, and each consumed count is compared against an arithmetic model of the rules.

The second is the output register draining and reloading in one cycle. This is driven by keeping `grp_ready_i` high while the window stays valid, and mixing in stretches of back-pressure. The bench judges `in_ready_o`, `take_o` and the held group against its own model of the register.

// File: rtl/grp_pkg.sv
package grp_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_BR    = 2'd1,
    CLS_PBR   = 2'd2,
    CLS_FP    = 2'd3
  } cls_e;

  typedef struct packed {
    logic       last;
    logic       first;
    logic [1:0] crack;
    cls_e       cls;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/grp_slot_rule.sv
// History-free legality and termination of one slot position.
module grp_slot_rule import grp_pkg::*; #(
  parameter int GRP_W      = 8,
  parameter int SLOT       = 0,
  parameter int PB_SLOT_ST = 5,
  parameter int PB_SLOT_MT = 3
) (
  input  ctrl_t ctrl_i,
  input  logic  mt_i,
  output logic  pos_ok_o,
  output logic  ends_o,
  output logic  is_br_o,
  output logic  is_fp_o
);
  localparam int MT_W    = GRP_W / 2;
  localparam int HALF_ST = GRP_W / 2;
  localparam int HALF_MT = MT_W / 2;
  localparam bit FIT_MT  = SLOT < MT_W;
  localparam bit LOW_ST  = SLOT < HALF_ST;
  localparam bit LOW_MT  = SLOT < HALF_MT;
  localparam bit PB_ST   = SLOT == PB_SLOT_ST;
  localparam bit PB_MT   = SLOT == PB_SLOT_MT;

  logic pbr_bad, c2_bad;

  assign is_br_o = ctrl_i.cls == CLS_BR;
  assign is_fp_o = ctrl_i.cls == CLS_FP;
  assign ends_o  = ctrl_i.last || (ctrl_i.crack == 2'd3);

  assign pbr_bad = (ctrl_i.cls == CLS_PBR) && !(mt_i ? PB_MT : PB_ST);
  assign c2_bad  = (ctrl_i.crack == 2'd2) && !(mt_i ? LOW_MT : LOW_ST);

  generate
    if (SLOT == 0) begin : g_head
      // slot 0 is exempt: guarantees forward progress
      assign pos_ok_o = 1'b1;
    end else begin : g_body
      assign pos_ok_o = !ctrl_i.first && !pbr_bad && !c2_bad && !(mt_i && !FIT_MT);
    end
  endgenerate
endmodule

// File: rtl/grp_scan.sv
// Serial in-order scan: counts branches/non-branches and closes the group.
module grp_scan #(
  parameter int GRP_W  = 8,
  parameter int NB_MAX = 6,
  parameter int BR_MAX = 2,
  parameter int CNT_W  = $clog2(GRP_W + 1)
) (
  input  logic [GRP_W-1:0] pos_ok_i,
  input  logic [GRP_W-1:0] ends_i,
  input  logic [GRP_W-1:0] is_br_i,
  input  logic [GRP_W-1:0] is_fp_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] take_o
);
  logic             open;
  logic             seen_br;
  logic             ok;
  logic [CNT_W-1:0] nb, br, take;

  always_comb begin
    open    = 1'b1;
    seen_br = 1'b0;
    ok      = 1'b0;
    nb      = '0;
    br      = '0;
    take    = '0;
    for (int i = 0; i < GRP_W; i++) begin
      if (open && (CNT_W'(i) < cnt_i)) begin
        ok = pos_ok_i[i]
             && !(is_fp_i[i] && seen_br)
             && !(!is_br_i[i] && (nb == CNT_W'(NB_MAX)))
             && !(is_br_i[i] && (br == CNT_W'(BR_MAX)));
        if (ok) begin
          take = take + 1'b1;
          if (is_br_i[i]) begin
            br      = br + 1'b1;
            seen_br = 1'b1;
          end else begin
            nb = nb + 1'b1;
          end
          if (ends_i[i] || (br == CNT_W'(BR_MAX))) open = 1'b0;
        end else begin
          open = 1'b0;
        end
      end
    end
    take_o = take;
  end
endmodule

// File: rtl/grp_out_reg.sv
module grp_out_reg #(
  parameter int GRP_W  = 8,
  parameter int CTRL_W = 6,
  parameter int TAG_W  = 8,
  parameter int CNT_W  = $clog2(GRP_W + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    load_i,
  input  logic [CNT_W-1:0]        take_i,
  input  logic [GRP_W*CTRL_W-1:0] ctrl_i,
  input  logic [GRP_W*TAG_W-1:0]  tag_i,
  output logic                    valid_o,
  output logic [GRP_W-1:0]        mask_o,
  output logic [GRP_W*CTRL_W-1:0] ctrl_o,
  output logic [GRP_W*TAG_W-1:0]  tag_o
);
  logic [GRP_W-1:0] mask_d;

  always_comb begin
    for (int i = 0; i < GRP_W; i++) mask_d[i] = CNT_W'(i) < take_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mask_o  <= '0;
      ctrl_o  <= '0;
      tag_o   <= '0;
    end else if (en_i) begin
      valid_o <= load_i;
      if (load_i) begin
        mask_o <= mask_d;
        ctrl_o <= ctrl_i;
        tag_o  <= tag_i;
      end
    end
  end
endmodule

// File: rtl/grp_former.sv
module grp_former import grp_pkg::*; #(
  parameter int GRP_W      = 8,
  parameter int TAG_W      = 8,
  parameter int NB_MAX     = 6,
  parameter int BR_MAX     = 2,
  parameter int PB_SLOT_ST = 5,
  parameter int PB_SLOT_MT = 3,
  localparam int CNT_W     = $clog2(GRP_W + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mt_i,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [CNT_W-1:0]        win_cnt_i,
  input  logic [GRP_W*CTRL_W-1:0] win_ctrl_i,
  input  logic [GRP_W*TAG_W-1:0]  win_tag_i,
  output logic [CNT_W-1:0]        take_o,
  output logic                    grp_valid_o,
  input  logic                    grp_ready_i,
  output logic [GRP_W-1:0]        grp_mask_o,
  output logic [GRP_W*CTRL_W-1:0] grp_ctrl_o,
  output logic [GRP_W*TAG_W-1:0]  grp_tag_o
);
  logic [GRP_W-1:0] pos_ok, ends, is_br, is_fp;
  logic [CNT_W-1:0] take;
  logic             fire;

  for (genvar s = 0; s < GRP_W; s++) begin : g_slot
    grp_slot_rule #(
      .GRP_W(GRP_W), .SLOT(s), .PB_SLOT_ST(PB_SLOT_ST), .PB_SLOT_MT(PB_SLOT_MT)
    ) u_rule (
      .ctrl_i  (ctrl_t'(win_ctrl_i[s*CTRL_W +: CTRL_W])),
      .mt_i    (mt_i),
      .pos_ok_o(pos_ok[s]),
      .ends_o  (ends[s]),
      .is_br_o (is_br[s]),
      .is_fp_o (is_fp[s])
    );
  end

  grp_scan #(.GRP_W(GRP_W), .NB_MAX(NB_MAX), .BR_MAX(BR_MAX), .CNT_W(CNT_W)) u_scan (
    .pos_ok_i(pos_ok),
    .ends_i  (ends),
    .is_br_i (is_br),
    .is_fp_i (is_fp),
    .cnt_i   (win_cnt_i),
    .take_o  (take)
  );

  assign in_ready_o = !grp_valid_o || grp_ready_i;
  assign fire       = in_valid_i && (win_cnt_i != '0);
  assign take_o     = (fire && in_ready_o) ? take : '0;

  grp_out_reg #(.GRP_W(GRP_W), .CTRL_W(CTRL_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (in_ready_o),
    .load_i (fire),
    .take_i (take),
    .ctrl_i (win_ctrl_i),
    .tag_i  (win_tag_i),
    .valid_o(grp_valid_o),
    .mask_o (grp_mask_o),
    .ctrl_o (grp_ctrl_o),
    .tag_o  (grp_tag_o)
  );
endmodule

// File: rtl/grp_former_chk.sv
module grp_former_chk import grp_pkg::*; #(
  parameter int GRP_W  = 8,
  parameter int TAG_W  = 8,
  parameter int NB_MAX = 6,
  parameter int BR_MAX = 2,
  parameter int CNT_W  = $clog2(GRP_W + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    mt_i,
  input logic                    in_valid_i,
  input logic                    in_ready_o,
  input logic [CNT_W-1:0]        win_cnt_i,
  input logic [CNT_W-1:0]        take_o,
  input logic                    grp_valid_o,
  input logic                    grp_ready_i,
  input logic [GRP_W-1:0]        grp_mask_o,
  input logic [GRP_W*CTRL_W-1:0] grp_ctrl_o,
  input logic [GRP_W*TAG_W-1:0]  grp_tag_o
);
  logic [GRP_W-1:0] br_v, nb_v;

  always_comb begin
    for (int i = 0; i < GRP_W; i++) begin
      br_v[i] = grp_mask_o[i] && (grp_ctrl_o[i*CTRL_W +: 2] == 2'(CLS_BR));
      nb_v[i] = grp_mask_o[i] && (grp_ctrl_o[i*CTRL_W +: 2] != 2'(CLS_BR));
    end
  end

  p_take_le_cnt_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o <= win_cnt_i);
  p_mt_width_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mt_i |-> take_o <= CNT_W'(GRP_W / 2));
  p_nb_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o |-> $countones(nb_v) <= NB_MAX);
  p_br_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o |-> $countones(br_v) <= BR_MAX);
  p_progress_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && win_cnt_i != '0) |-> take_o != '0);
  p_no_take_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> take_o == '0);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_valid_o && !grp_ready_i) |=> grp_valid_o && $stable(grp_mask_o)
      && $stable(grp_ctrl_o) && $stable(grp_tag_o));
  p_mask_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o |-> grp_mask_o[0] && (((grp_mask_o + 1'b1) & grp_mask_o) == '0));
endmodule

bind grp_former grp_former_chk #(
  .GRP_W(GRP_W), .TAG_W(TAG_W), .NB_MAX(NB_MAX), .BR_MAX(BR_MAX), .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mt_i       (mt_i),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .win_cnt_i  (win_cnt_i),
  .take_o     (take_o),
  .grp_valid_o(grp_valid_o),
  .grp_ready_i(grp_ready_i),
  .grp_mask_o (grp_mask_o),
  .grp_ctrl_o (grp_ctrl_o),
  .grp_tag_o  (grp_tag_o)
);

// File: tb/grp_former_test.sv
`timescale 1ns/100ps
module grp_former_test;
  localparam int W = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mt = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [3:0]    win_cnt = '0;
  logic [W*6-1:0] win_ctrl;
  logic [W*8-1:0] win_tag;
  logic [3:0]    take;
  logic          grp_valid;
  logic          grp_ready = 1'b1;
  logic [W-1:0]  grp_mask;
  logic [W*6-1:0] grp_ctrl;
  logic [W*8-1:0] grp_tag;

  logic [5:0] wc [W];
  logic [7:0] wt [W];

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  bit         ev = 1'b0;
  logic [W-1:0] emask;
  logic [7:0] etag [W];
  logic [5:0] ectl [W];
  logic [31:0] lfsr = 32'h1ace_b00c;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      win_ctrl[i*6 +: 6] = wc[i];
      win_tag[i*8 +: 8]  = wt[i];
    end
  end

  grp_former uut (
    .clk_i(clk), .rst_ni(rst_ni), .mt_i(mt), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .win_cnt_i(win_cnt), .win_ctrl_i(win_ctrl),
    .win_tag_i(win_tag), .take_o(take), .grp_valid_o(grp_valid),
    .grp_ready_i(grp_ready), .grp_mask_o(grp_mask), .grp_ctrl_o(grp_ctrl),
    .grp_tag_o(grp_tag)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ctrl: last[5] first[4] crack[3:2] cls[1:0]
  function automatic logic [5:0] mk(int cls, int cr, bit f, bit l);
    return {l, f, 2'(cr), 2'(cls)};
  endfunction

  task automatic fill(int n, bit m);
    for (int i = 0; i < W; i++) begin
      wc[i] = mk(0, 1, 0, 0);
      wt[i] = 8'(lfsr[7:0] + i);
    end
    win_cnt = 4'(n);
    mt = m;
    in_valid = 1'b1;
  endtask

  function automatic int model(bit m, int cnt);
    int w = m ? 4 : 8;
    int pbs = m ? 3 : 5;
    int nb = 0;
    int br = 0;
    bit sb = 0;
    for (int i = 0; i < cnt && i < w; i++) begin
      int cls = int'(wc[i][1:0]);
      int cr = int'(wc[i][3:2]);
      if (i > 0) begin
        if (wc[i][4]) return i;
        if (cls == 2 && i != pbs) return i;
        if (cr == 2 && i >= w / 2) return i;
        if (cls == 3 && sb) return i;
        if (cls != 1 && nb == 6) return i;
      end
      if (cls == 1) begin br++; sb = 1; end else nb++;
      if (wc[i][5] || cr == 3 || br == 2) return i + 1;
    end
    return (cnt < w) ? cnt : w;
  endfunction

  // inputs driven just after negedge; combinational outputs sampled before posedge
  task automatic cycle(int exp_take, string req);
    bit rdy, fire;
    int et;
    #1;
    rdy = !ev || grp_ready;
    fire = in_valid && (win_cnt != 0) && rdy;
    et = fire ? exp_take : 0;
    chk(in_ready == rdy, "R10", int'(in_ready), int'(rdy));
    chk(int'(take) == et, req, int'(take), et);
    if (rdy) begin
      ev = fire;
      if (fire) begin
        for (int i = 0; i < W; i++) begin
          emask[i] = i < exp_take;
          etag[i] = wt[i];
          ectl[i] = wc[i];
        end
      end
    end
    @(posedge clk);
    #1;
    chk(grp_valid == ev, "R10", int'(grp_valid), int'(ev));
    if (ev) begin
      chk(grp_mask == emask, "R11", int'(grp_mask), int'(emask));
      for (int i = 0; i < W; i++) begin
        if (emask[i])
          chk(grp_tag[i*8 +: 8] == etag[i] && grp_ctrl[i*6 +: 6] == ectl[i], "R11",
              int'(grp_tag[i*8 +: 8]), int'(etag[i]));
      end
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] step(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < W; i++) begin wc[i] = '0; wt[i] = '0; end
    #9;
    chk(grp_valid == 1'b0 && take == 0, "R10", int'(grp_valid), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10", int'(in_ready), 1);

    // R1 full width: six plain then two branches
    fill(8, 0); wc[6] = mk(1, 1, 0, 0); wc[7] = mk(1, 1, 0, 0); cycle(8, "R1");
    fill(6, 1); cycle(4, "R1");
    fill(3, 0); cycle(3, "R1");
    // R2 non-branch cap
    fill(8, 0); cycle(6, "R2");
    // R3 second branch closes
    fill(5, 0); wc[0] = mk(1, 1, 0, 0); wc[2] = mk(1, 1, 0, 0); cycle(3, "R3");
    // R4 predicated slot
    fill(8, 0); wc[2] = mk(2, 1, 0, 0); cycle(2, "R4");
    fill(8, 0); wc[5] = mk(2, 1, 0, 0); cycle(6, "R4");
    fill(6, 1); wc[3] = mk(2, 1, 0, 0); cycle(4, "R4");
    fill(6, 1); wc[1] = mk(2, 1, 0, 0); cycle(1, "R4");
    // R5 crack 2 in first half
    fill(8, 0); wc[4] = mk(0, 2, 0, 0); cycle(4, "R5");
    fill(8, 0); wc[3] = mk(0, 2, 0, 0); cycle(6, "R5");
    fill(6, 1); wc[2] = mk(0, 2, 0, 0); cycle(2, "R5");
    fill(6, 1); wc[1] = mk(0, 2, 0, 0); cycle(4, "R5");
    // R6 crack 3 closes after
    fill(8, 0); wc[1] = mk(0, 3, 0, 0); cycle(2, "R6");
    // R7 fp after branch
    fill(8, 0); wc[0] = mk(1, 1, 0, 0); wc[2] = mk(3, 1, 0, 0); cycle(2, "R7");
    fill(4, 0); wc[0] = mk(3, 1, 0, 0); wc[2] = mk(1, 1, 0, 0); cycle(4, "R7");
    // R8 ordering flags
    fill(8, 0); wc[1] = mk(0, 1, 1, 0); cycle(1, "R8");
    fill(8, 0); wc[1] = mk(0, 1, 0, 1); cycle(2, "R8");
    fill(8, 0); wc[0] = mk(0, 1, 1, 1); cycle(1, "R8");
    fill(3, 0); wc[0] = mk(0, 1, 1, 0); cycle(3, "R8");
    // R9 progress and empty window
    fill(2, 0); wc[0] = mk(2, 1, 0, 0); cycle(2, "R9");
    fill(8, 1); wc[0] = mk(3, 2, 1, 0); wc[1] = mk(0, 1, 1, 0); cycle(1, "R9");
    fill(0, 0); cycle(0, "R9");
    // R10 back-pressure: group held, nothing taken
    fill(8, 0); cycle(6, "R10");
    grp_ready = 1'b0;
    fill(3, 0); wc[0] = mk(1, 3, 0, 0); cycle(1, "R10");
    cycle(1, "R10");
    grp_ready = 1'b1;
    cycle(1, "R10");

    // pseudo-random sweep over both widths with back-pressure bursts
    for (int n = 0; n < 6000; n++) begin
      lfsr = step(lfsr);
      mt = lfsr[0];
      win_cnt = 4'(lfsr[4:1] % 9);
      in_valid = lfsr[5] | lfsr[6];
      grp_ready = lfsr[7] | lfsr[8];
      for (int i = 0; i < W; i++) begin
        logic [31:0] r;
        r = step(lfsr ^ 32'(i * 32'h9e37_79b9));
        wc[i] = mk(int'(r[1:0]), int'(r[3:2]), r[6:4] == 0, r[9:7] == 0);
        wt[i] = r[17:10];
      end
      cycle(model(mt, int'(win_cnt)), "R1");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule